// File: doc/BRIEF.md
# Key-Protected Chip Reset Controller

This block accepts chip-reset requests from three kinds of source and turns each one into a single-cycle reset-request pulse. The sources are a software write, an external reset input and a set of watchdog trip lines. Together with the pulse it drives a flag that tells the downstream reset sequencer whether the reset should be soft or hard. Software reaches it through a plain 32-bit register port with a byte address. There are four word registers: a read-only cause record, a control word, a configuration word and an isolation word.

The control and configuration words are guarded. A write to either one takes effect only right after a 16-bit unlock key has been written to the low half of the control word. One guarded write uses up the unlock. A software reset is requested by writing a zero, not a one, to the trigger bit of the control word. The cause register keeps the source of the most recent request. The isolation word is storage only.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the control word reads 0x0001_0000, the configuration word reads 0, the isolation word reads 0xFFFF_FFFF, and `rstReqPulse` and `rstIsSoft` are both 0.
- R2: Address bits [3:2] select the register: 0x0 is the cause register, 0x4 the control word, 0x8 the configuration word (16 bits, zero-extended) and 0xC the isolation word (32 bits).
- R3: While locked, a control-word write whose bits [15:0] equal 0x5A69 unlocks the guarded registers and has no other effect. Any other value leaves the block locked and sets no flag.
- R4: While unlocked, the next write to the control or configuration word takes effect and relocks the block. Writes to 0x0 or 0xC do not use up the unlock.
- R5: While locked, writes to the control or configuration word change no register and raise no reset request.
- R6: An unlocked control-word write with bit 16 = 0 raises `rstReqPulse` for exactly the one cycle after the write edge. With bit 16 = 1 it raises no pulse.
- R7: On the edge that raises `rstReqPulse`, `rstIsSoft` is loaded with 1 if the configuration word equals 0x300F and with 0 otherwise. Between requests it holds its value.
- R8: Reads of the control word always return 0x0001_0000, so the key bits are never shown.
- R9: The isolation word can be written at any time without the key and reads back what was written. Writes to the cause register are ignored.
- R10: A rising edge on `extRstReq` or on `wdogTrip[k]` raises `rstReqPulse` in the next cycle. The cause register is loaded with a one-hot code: bit 0 for the external input, bit 1 for software, bit 2+k for watchdog k. When requests coincide, the priority is external first, then software, then the lowest-numbered watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Combinational read data for `busAddr` |
| extRstReq | input | 1 | External reset request, acts on its rising edge |
| wdogTrip | input | NUM_WDOG | Watchdog trip lines, each acting on its rising edge |
| rstReqPulse | output | 1 | Single-cycle chip-reset request |
| rstIsSoft | output | 1 | Reset type captured with the last request (1 = soft) |

## Verification
The hardest state to reach is the one-write unlock window, because the unlock flag cannot be read. Every claim about it is therefore shown through its effect on a later write. The stimulus opens the window and first spends writes to the isolation and cause registers, which must not close it. It then makes one guarded write that must land, and a second one that must be dropped. Readback of the configuration word shows which writes landed. Coincident requests are produced by rising two sources in the same cycle, including a software trigger write, so that the cause register shows the priority order.

// File: rtl/krc_pkg.sv
package krc_pkg;
  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_ISO   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWe;
    logic isoWe;
    logic fire;
  } strobe_t;

  localparam int TRIG_BIT = 16;
endpackage

// File: rtl/krc_control.sv
module krc_control
  import krc_pkg::*;
#(
  parameter int          NUM_WDOG   = 4,
  parameter logic [15:0] UNLOCK_KEY = 16'h5A69,
  localparam int         CAUSE_W    = NUM_WDOG + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regAddr,
  input  logic                busWrEn,
  input  logic [TRIG_BIT:0]   ctrlData,
  input  logic                extRstReq,
  input  logic [NUM_WDOG-1:0] wdogTrip,
  output strobe_t             strb,
  output logic [CAUSE_W-1:0]  causeCode,
  output logic                unlocked
);
  regSel_e sel;
  logic selCtrl, selCfg, selIso, guardedWr, keyMatch, swTrig;
  logic extPrev, extRise;
  logic [NUM_WDOG-1:0] wdogPrev, wdogRise;

  assign sel       = regSel_e'(regAddr);
  assign selCtrl   = (sel == SEL_CTRL);
  assign selCfg    = (sel == SEL_CFG);
  assign selIso    = (sel == SEL_ISO);
  assign guardedWr = busWrEn && (selCtrl || selCfg);
  assign keyMatch  = (ctrlData[15:0] == UNLOCK_KEY);

  // unlock window: opened by key, consumed by next guarded write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlocked <= 1'b0;
    else if (guardedWr) begin
      if (unlocked)                  unlocked <= 1'b0;
      else if (selCtrl && keyMatch)  unlocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      wdogPrev <= '0;
    end else begin
      extPrev  <= extRstReq;
      wdogPrev <= wdogTrip;
    end
  end

  assign extRise  = extRstReq & ~extPrev;
  assign wdogRise = wdogTrip & ~wdogPrev;
  assign swTrig   = busWrEn && selCtrl && unlocked && !ctrlData[TRIG_BIT];

  // priority: external, software, lowest watchdog
  always_comb begin
    logic found;
    causeCode = '0;
    found     = 1'b0;
    if (extRise) begin
      causeCode[0] = 1'b1;
      found        = 1'b1;
    end else if (swTrig) begin
      causeCode[1] = 1'b1;
      found        = 1'b1;
    end
    for (int k = 0; k < NUM_WDOG; k++) begin
      if (!found && wdogRise[k]) begin
        causeCode[k+2] = 1'b1;
        found          = 1'b1;
      end
    end
  end

  assign strb.fire  = extRise || swTrig || (|wdogRise);
  assign strb.cfgWe = busWrEn && selCfg && unlocked;
  assign strb.isoWe = busWrEn && selIso;
endmodule

// File: rtl/krc_datapath.sv
module krc_datapath
  import krc_pkg::*;
#(
  parameter int           DATA_W    = 32,
  parameter int           CFG_W     = 16,
  parameter int           ISO_W     = 32,
  parameter int           CAUSE_W   = 6,
  parameter logic [CFG_W-1:0] SOFT_CODE = 16'h300F,
  parameter logic [ISO_W-1:0] ISO_RST   = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  wData,
  input  strobe_t            strb,
  input  logic [CAUSE_W-1:0] causeCode,
  output logic [DATA_W-1:0]  busRData,
  output logic               rstReqPulse,
  output logic               rstIsSoft,
  output logic [CFG_W-1:0]   cfgVal,
  output logic [ISO_W-1:0]   isoVal
);
  localparam logic [DATA_W-1:0] CTRL_READ = DATA_W'(1) << TRIG_BIT;

  logic [CAUSE_W-1:0] causeVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVal <= '0;
      isoVal <= ISO_RST;
    end else begin
      if (strb.cfgWe) cfgVal <= wData[CFG_W-1:0];
      if (strb.isoWe) isoVal <= wData[ISO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeVal    <= '0;
      rstReqPulse <= 1'b0;
      rstIsSoft   <= 1'b0;
    end else begin
      rstReqPulse <= strb.fire;
      if (strb.fire) begin
        causeVal  <= causeCode;
        rstIsSoft <= (cfgVal == SOFT_CODE);
      end
    end
  end

  always_comb begin
    unique case (regSel_e'(regAddr))
      SEL_CAUSE: busRData = DATA_W'(causeVal);
      SEL_CTRL:  busRData = CTRL_READ;
      SEL_CFG:   busRData = DATA_W'(cfgVal);
      default:   busRData = DATA_W'(isoVal);
    endcase
  end
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl
  import krc_pkg::*;
#(
  parameter int NUM_WDOG = 4,
  parameter int CFG_W    = 16,
  parameter int ISO_W    = 32,
  parameter logic [15:0]      UNLOCK_KEY = 16'h5A69,
  parameter logic [CFG_W-1:0] SOFT_CODE  = 16'h300F,
  localparam int DATA_W  = 32,
  localparam int CAUSE_W = NUM_WDOG + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  input  logic                extRstReq,
  input  logic [NUM_WDOG-1:0] wdogTrip,
  output logic                rstReqPulse,
  output logic                rstIsSoft
);
  strobe_t            strb;
  logic [CAUSE_W-1:0] causeCode;
  logic               unlocked;
  logic [CFG_W-1:0]   cfgVal;
  logic [ISO_W-1:0]   isoVal;
  logic [1:0]         unusedAddrBits;

  assign unusedAddrBits = busAddr[1:0];

  krc_control #(.NUM_WDOG(NUM_WDOG), .UNLOCK_KEY(UNLOCK_KEY)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(busAddr[3:2]), .busWrEn(busWrEn),
    .ctrlData(busWData[TRIG_BIT:0]), .extRstReq(extRstReq),
    .wdogTrip(wdogTrip), .strb(strb), .causeCode(causeCode),
    .unlocked(unlocked)
  );

  krc_datapath #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .ISO_W(ISO_W), .CAUSE_W(CAUSE_W),
    .SOFT_CODE(SOFT_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(busAddr[3:2]), .wData(busWData),
    .strb(strb), .causeCode(causeCode), .busRData(busRData),
    .rstReqPulse(rstReqPulse), .rstIsSoft(rstIsSoft),
    .cfgVal(cfgVal), .isoVal(isoVal)
  );
endmodule

// File: rtl/krc_checker.sv
module krc_checker #(
  parameter int CFG_W = 16,
  parameter int ISO_W = 32,
  parameter logic [15:0]      UNLOCK_KEY = 16'h5A69,
  parameter logic [CFG_W-1:0] SOFT_CODE  = 16'h300F
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       busAddr,
  input logic             busWrEn,
  input logic [31:0]      busWData,
  input logic             unlocked,
  input logic [CFG_W-1:0] cfgVal,
  input logic [ISO_W-1:0] isoVal,
  input logic             rstReqPulse,
  input logic             rstIsSoft
);
  logic wrCtrl, wrCfg, wrIso;
  assign wrCtrl = busWrEn && (busAddr[3:2] == 2'd1);
  assign wrCfg  = busWrEn && (busAddr[3:2] == 2'd2);
  assign wrIso  = busWrEn && (busAddr[3:2] == 2'd3);

  // R3
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && wrCtrl && busWData[15:0] == UNLOCK_KEY) |=> unlocked);

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && (wrCtrl || wrCfg)) |=> !unlocked);

  // R5
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && wrCfg) |=> $stable(cfgVal));

  // R6
  sw_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && wrCtrl && !busWData[16]) |=> rstReqPulse);

  // R7
  soft_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && wrCtrl && !busWData[16]) |=>
      (rstIsSoft == ($past(cfgVal) == SOFT_CODE)));

  // R9
  iso_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrIso |=> (isoVal == $past(busWData[ISO_W-1:0])));
endmodule

bind keyed_reset_ctrl krc_checker #(
  .CFG_W(CFG_W), .ISO_W(ISO_W), .UNLOCK_KEY(UNLOCK_KEY), .SOFT_CODE(SOFT_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWData(busWData), .unlocked(unlocked), .cfgVal(cfgVal),
  .isoVal(isoVal), .rstReqPulse(rstReqPulse), .rstIsSoft(rstIsSoft)
);

// File: tb/sim_keyed_reset_ctrl.sv
`timescale 1ns/1ps
module sim_keyed_reset_ctrl;
  localparam int NW = 4;
  localparam logic [3:0] A_CAUSE = 4'h0, A_CTRL = 4'h4, A_CFG = 4'h8, A_ISO = 4'hC;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, extRstReq = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWData = '0, busRData;
  logic [NW-1:0] wdogTrip = '0;
  logic rstReqPulse, rstIsSoft;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  keyed_reset_ctrl #(.NUM_WDOG(NW)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWData(busWData), .busRData(busRData), .extRstReq(extRstReq),
    .wdogTrip(wdogTrip), .rstReqPulse(rstReqPulse), .rstIsSoft(rstIsSoft)
  );

  typedef struct packed {
    logic        isWr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;   // read value, or expected pulse for writes
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, A_CAUSE, 32'h0, 32'h0,          4'd1},  // R1
    '{1'b0, A_CTRL,  32'h0, 32'h0001_0000,  4'd1},  // R1
    '{1'b0, A_CFG,   32'h0, 32'h0,          4'd1},  // R1
    '{1'b0, A_ISO,   32'h0, 32'hFFFF_FFFF,  4'd1},  // R1
    '{1'b1, A_CFG,   32'h300F, 32'h0,       4'd5},  // R5 locked write
    '{1'b0, A_CFG,   32'h0, 32'h0,          4'd5},
    '{1'b1, A_CTRL,  32'h1234, 32'h0,       4'd3},  // R3 wrong key
    '{1'b1, A_CFG,   32'h300F, 32'h0,       4'd3},
    '{1'b0, A_CFG,   32'h0, 32'h0,          4'd3},
    '{1'b1, A_CTRL,  32'h0001_5A69, 32'h0,  4'd3},  // R3 key
    '{1'b1, A_ISO,   32'h0, 32'h0,          4'd9},  // R9 / R4 no consume
    '{1'b0, A_ISO,   32'h0, 32'h0,          4'd9},
    '{1'b1, A_CAUSE, 32'hFF, 32'h0,         4'd9},  // R9 ignored write
    '{1'b0, A_CAUSE, 32'h0, 32'h0,          4'd9},
    '{1'b1, A_CFG,   32'h300F, 32'h0,       4'd4},  // R4 lands
    '{1'b0, A_CFG,   32'h0, 32'h300F,       4'd4},
    '{1'b1, A_CFG,   32'h0, 32'h0,          4'd4},  // R4 relocked
    '{1'b0, A_CFG,   32'h0, 32'h300F,       4'd4},
    '{1'b1, A_CTRL,  32'h5A69, 32'h0,       4'd8},  // R8 key hidden
    '{1'b0, A_CTRL,  32'h0, 32'h0001_0000,  4'd8},
    '{1'b1, A_CTRL,  32'h0001_0000, 32'h0,  4'd6},  // R6 bit16=1 no pulse
    '{1'b0, A_CAUSE, 32'h0, 32'h0,          4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write at one edge; return at the next negedge, when pulse is visible
  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #0.5;
  endtask

  task automatic readChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    busAddr = a;
    #0.5;
    check(req, busRData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 pulse", {31'b0, rstReqPulse}, 32'h0);
    check("R1 soft", {31'b0, rstIsSoft}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].isWr) begin
        doWrite(VECS[i].addr, VECS[i].data);
        check(tag, {31'b0, rstReqPulse}, VECS[i].exp);
      end else begin
        readChk(tag, VECS[i].addr, VECS[i].exp);
      end
    end

    // R6 / R7: software trigger with soft config (cfg is 0x300F)
    doWrite(A_CTRL, 32'h5A69);
    doWrite(A_CTRL, 32'h0);
    check("R6 sw pulse", {31'b0, rstReqPulse}, 32'h1);
    check("R7 soft", {31'b0, rstIsSoft}, 32'h1);
    readChk("R10 sw cause", A_CAUSE, 32'h2);
    @(negedge clk); #0.5;
    check("R6 pulse width", {31'b0, rstReqPulse}, 32'h0);

    // R5: locked trigger write does nothing
    doWrite(A_CTRL, 32'h0);
    check("R5 locked trig", {31'b0, rstReqPulse}, 32'h0);

    // R7: hard config, then software trigger
    doWrite(A_CTRL, 32'h5A69);
    doWrite(A_CFG, 32'h0);
    check("R7 hold", {31'b0, rstIsSoft}, 32'h1);
    doWrite(A_CTRL, 32'h5A69);
    doWrite(A_CTRL, 32'h0);
    check("R7 hard", {31'b0, rstIsSoft}, 32'h0);

    // R10: external rise, held high gives one pulse
    @(negedge clk); extRstReq = 1'b1;
    @(negedge clk); #0.5;
    check("R10 ext pulse", {31'b0, rstReqPulse}, 32'h1);
    readChk("R10 ext cause", A_CAUSE, 32'h1);
    @(negedge clk); #0.5;
    check("R10 ext level", {31'b0, rstReqPulse}, 32'h0);
    extRstReq = 1'b0;

    // R10: watchdog 2 -> bit 4
    @(negedge clk); wdogTrip = 4'b0100;
    @(negedge clk); #0.5;
    check("R10 wdog pulse", {31'b0, rstReqPulse}, 32'h1);
    readChk("R10 wdog cause", A_CAUSE, 32'h10);
    wdogTrip = '0;

    // R10: external beats watchdog 1 and 3
    @(negedge clk); extRstReq = 1'b1; wdogTrip = 4'b1010;
    @(negedge clk); #0.5;
    readChk("R10 ext prio", A_CAUSE, 32'h1);
    extRstReq = 1'b0; wdogTrip = '0;

    // R10: watchdogs 1 and 3 together -> lowest wins
    @(negedge clk); wdogTrip = 4'b1010;
    @(negedge clk); #0.5;
    readChk("R10 wdog prio", A_CAUSE, 32'h8);
    wdogTrip = '0;

    // R10: software beats watchdog 0
    doWrite(A_CTRL, 32'h5A69);
    @(negedge clk);
    busAddr = A_CTRL; busWData = 32'h0; busWrEn = 1'b1; wdogTrip = 4'b0001;
    @(negedge clk);
    busWrEn = 1'b0; #0.5;
    check("R10 sw pulse", {31'b0, rstReqPulse}, 32'h1);
    readChk("R10 sw prio", A_CAUSE, 32'h2);
    wdogTrip = '0;

    // R2: address low bits do not change selection
    readChk("R2 alias", 4'hB, 32'h0);
    readChk("R2 iso", 4'hE, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule